// File: doc/BRIEF.md
# Banked Floating-Point Register File with Move Unit

This block holds thirty-two 32-bit floating-point registers, arranged as two banks of sixteen, together with a 22-bit status register. Instructions name registers with 4-bit logical indices. The status register decides which bank those indices reach and whether a transfer moves one word or a 64-bit pair. Arithmetic units and instruction decoding sit outside the block. A decoder presents one command at a time. A command can be a move between memory and a register, a move between two registers, a toggle of one status bit, or a write of the whole status register.

For moves to and from memory, the decoder supplies the value of the address register and, for indexed forms, the value of register zero. The block then works out every word address and performs the words one at a time over a request/acknowledge handshake. When the command finishes, it returns the updated address register value for the post-increment and pre-decrement forms. A registered read port exposes any physical register by its 5-bit physical number.

Top module: `fp_bank_regfile`

## Requirements
- R1: Synchronous reset clears all 32 registers and the status register to zero, raises `cmd_ready`, and leaves `mem_req`, `cmd_done` and `gpr_wb_valid` low.
- R2: Status bit 21 selects the bank. A logical index reaches physical register `index XOR 16` when the bit is set, and `index` when it is clear.
- R3: When status bit 20 (paired mode) is set, an odd logical index is first turned into index+15. It therefore names the even/odd pair in the other bank, and bank selection is applied after this step.
- R4: A paired load makes two requests, the first to address+4 and the second to address. The first word goes to the pair's even member and the second word to its odd member.
- R5: A paired store writes the even member to address+4 first, then the odd member to address.
- R6: Post-increment loads use the supplied base as the address. They return base+8 in paired mode and base+4 in single mode on `gpr_wb_data`, with `gpr_wb_valid` high in the `cmd_done` cycle.
- R7: Pre-decrement stores first subtract 8 (paired) or 4 (single) from the base. They access the lowered address and return it as the write-back value.
- R8: The indexed forms use base plus `cmd_ofs` as the address.
- R9: Op codes 8, 9 and 10 each invert exactly one status bit: 20, 19 and 21 respectively. No other command changes the status register except op 11.
- R10: Op 11 loads the status register from the low 22 bits of `cmd_wdata`. Higher bits are dropped.
- R11: Only one memory word is outstanding at a time. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold until `mem_ack`, and `cmd_ready` stays low while a transfer is in flight.
- R12: A register-to-register move (op 7) copies one word in single mode, or both words of a pair in paired mode. It completes with `cmd_done` in the cycle after acceptance.
- R13: In single mode, a memory move performs exactly one word access at its address.

Op codes: 1 load, 2 indexed load, 3 post-increment load, 4 store, 5 indexed store, 6 pre-decrement store, 7 register move (source `cmd_m`, destination `cmd_n`), 8 size toggle, 9 precision toggle, 10 bank toggle, 11 status write. For memory moves, `cmd_n` names the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_op | input | 4 | Operation code |
| cmd_n | input | 4 | Destination / data register logical index |
| cmd_m | input | 4 | Source register logical index for moves |
| cmd_base | input | 32 | Current address register value |
| cmd_ofs | input | 32 | Register-zero value for indexed forms |
| cmd_wdata | input | 32 | Status write data |
| cmd_done | output | 1 | One-cycle pulse when a command finishes |
| gpr_wb_valid | output | 1 | Address register update present |
| gpr_wb_data | output | 32 | New address register value |
| stat_q | output | 22 | Status register |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory accepts / completes the word |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rd_phys | input | 5 | Physical register to observe |
| rd_data | output | 32 | Observed register, one cycle later |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high, and that `cmd_op` carries one of the defined codes whenever `cmd_valid` is high. The bench responder acknowledges only a pending request, pulses the acknowledge for one cycle, and sometimes stalls several cycles first so that the hold behaviour is exercised. The driver offers only listed op codes and waits for `cmd_done` before it offers the next command.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int STAT_W    = 22;
  localparam int BIT_BANK  = 21;
  localparam int BIT_SIZE  = 20;
  localparam int BIT_PREC  = 19;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LD     = 4'd1,
    OP_LDX    = 4'd2,
    OP_LDINC  = 4'd3,
    OP_ST     = 4'd4,
    OP_STX    = 4'd5,
    OP_STDEC  = 4'd6,
    OP_MOV    = 4'd7,
    OP_TGL_SZ = 4'd8,
    OP_TGL_PR = 4'd9,
    OP_TGL_BK = 4'd10,
    OP_WSTAT  = 4'd11
  } fp_op_e;

  typedef enum logic {S_IDLE, S_XFER} fp_state_e;
endpackage

// File: rtl/fprf_map.sv
// Logical-to-physical register index mapping with pair extension and banking.
module fprf_map #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             bank,
  input  logic             paired,
  output logic [IDX_W:0]   phys_even,
  output logic [IDX_W:0]   phys_odd
);
  localparam logic [IDX_W:0] PAIR_JUMP = (IDX_W+1)'((1 << IDX_W) - 1);
  localparam logic [IDX_W:0] BANK_MASK = (IDX_W+1)'(1 << IDX_W);

  logic [IDX_W:0] ext;

  always_comb begin
    ext = {1'b0, idx};
    if (paired && idx[0]) ext = {1'b0, idx} + PAIR_JUMP;
    phys_even = bank ? (ext ^ BANK_MASK) : ext;
    phys_odd  = {phys_even[IDX_W:1], 1'b1};
  end
endmodule

// File: rtl/fprf_store.sv
// Register storage: two write ports, two combinational reads, one registered observe port.
module fprf_store #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [DW-1:0] wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [DW-1:0] wd_b,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b,
  input  logic [AW-1:0] ra_o,
  output logic [DW-1:0] rq_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rq_o <= '0;
    end else begin
      if (we_a) mem[wa_a] <= wd_a;
      if (we_b) mem[wa_b] <= wd_b;
      rq_o <= mem[ra_o];
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/fp_bank_regfile.sv
module fp_bank_regfile
  import fprf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 4,
  parameter int AW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_n,
  input  logic [IDX_W-1:0]  cmd_m,
  input  logic [AW-1:0]     cmd_base,
  input  logic [AW-1:0]     cmd_ofs,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              cmd_done,
  output logic              gpr_wb_valid,
  output logic [AW-1:0]     gpr_wb_data,
  output logic [STAT_W-1:0] stat_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [IDX_W:0]    rd_phys,
  output logic [DW-1:0]     rd_data
);
  localparam int         PW       = IDX_W + 1;
  localparam int         WORD_B   = DW / 8;
  localparam logic [AW-1:0] STEP_1 = AW'(WORD_B);
  localparam logic [AW-1:0] STEP_2 = AW'(2 * WORD_B);

  fp_state_e state;
  fp_op_e    op;
  logic      acc, paired, bank, is_mem, is_store;
  logic      beat, two_beats, ld_q, wb_en;
  logic [PW-1:0] n_even, n_odd, m_even, m_odd, p0_q, p1_q;
  logic [AW-1:0] step, eff, lo_q, wb_val;

  logic          we_a, we_b;
  logic [PW-1:0] wa_a, ra_a, ra_b;
  logic [DW-1:0] wd_a, rd_a, rd_b;

  assign op        = fp_op_e'(cmd_op);
  assign cmd_ready = (state == S_IDLE);
  assign acc       = cmd_valid && cmd_ready;
  assign paired    = stat_q[BIT_SIZE];
  assign bank      = stat_q[BIT_BANK];
  assign step      = paired ? STEP_2 : STEP_1;
  assign is_mem    = op inside {OP_LD, OP_LDX, OP_LDINC, OP_ST, OP_STX, OP_STDEC};
  assign is_store  = op inside {OP_ST, OP_STX, OP_STDEC};

  fprf_map #(.IDX_W(IDX_W)) u_map_n (
    .idx(cmd_n), .bank(bank), .paired(paired), .phys_even(n_even), .phys_odd(n_odd));
  fprf_map #(.IDX_W(IDX_W)) u_map_m (
    .idx(cmd_m), .bank(bank), .paired(paired), .phys_even(m_even), .phys_odd(m_odd));

  always_comb begin
    unique case (op)
      OP_LDX, OP_STX: eff = cmd_base + cmd_ofs;
      OP_STDEC:       eff = cmd_base - step;
      default:        eff = cmd_base;
    endcase
  end

  // storage port steering
  assign ra_a = (op == OP_MOV) ? m_even : n_even;
  assign ra_b = (state == S_XFER) ? p1_q : m_odd;
  assign we_a = (acc && op == OP_MOV) || (state == S_XFER && mem_ack && ld_q);
  assign wa_a = (state == S_XFER) ? (beat ? p1_q : p0_q) : n_even;
  assign wd_a = (state == S_XFER) ? mem_rdata : rd_a;
  assign we_b = acc && op == OP_MOV && paired;

  fprf_store #(.DW(DW), .AW(PW)) u_store (
    .clk(clk), .rst(rst),
    .we_a(we_a), .wa_a(wa_a), .wd_a(wd_a),
    .we_b(we_b), .wa_b(n_odd), .wd_b(rd_b),
    .ra_a(ra_a), .rd_a(rd_a),
    .ra_b(ra_b), .rd_b(rd_b),
    .ra_o(rd_phys), .rq_o(rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      stat_q       <= '0;
      cmd_done     <= 1'b0;
      gpr_wb_valid <= 1'b0;
      gpr_wb_data  <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      beat         <= 1'b0;
      two_beats    <= 1'b0;
      ld_q         <= 1'b0;
      wb_en        <= 1'b0;
      wb_val       <= '0;
      p0_q         <= '0;
      p1_q         <= '0;
      lo_q         <= '0;
    end else begin
      cmd_done     <= 1'b0;
      gpr_wb_valid <= 1'b0;
      if (acc) begin
        if (is_mem) begin
          state     <= S_XFER;
          mem_req   <= 1'b1;
          mem_we    <= is_store;
          mem_addr  <= paired ? eff + STEP_1 : eff;
          mem_wdata <= rd_a;
          lo_q      <= eff;
          p0_q      <= n_even;
          p1_q      <= n_odd;
          beat      <= 1'b0;
          two_beats <= paired;
          ld_q      <= !is_store;
          wb_en     <= (op == OP_LDINC) || (op == OP_STDEC);
          wb_val    <= (op == OP_LDINC) ? cmd_base + step : cmd_base - step;
        end else begin
          cmd_done <= 1'b1;
          unique case (op)
            OP_TGL_SZ: stat_q[BIT_SIZE] <= !stat_q[BIT_SIZE];
            OP_TGL_PR: stat_q[BIT_PREC] <= !stat_q[BIT_PREC];
            OP_TGL_BK: stat_q[BIT_BANK] <= !stat_q[BIT_BANK];
            OP_WSTAT:  stat_q <= cmd_wdata[STAT_W-1:0];
            default: ;
          endcase
        end
      end else if (state == S_XFER && mem_ack) begin
        if (two_beats && !beat) begin
          beat      <= 1'b1;
          mem_addr  <= lo_q;
          mem_wdata <= rd_b;
        end else begin
          state        <= S_IDLE;
          mem_req      <= 1'b0;
          cmd_done     <= 1'b1;
          gpr_wb_valid <= wb_en;
          gpr_wb_data  <= wb_val;
        end
      end
    end
  end
endmodule

// File: rtl/fprf_chk.sv
module fprf_chk #(
  parameter int DW    = 32,
  parameter int IDX_W = 4,
  parameter int AW    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_op,
  input logic              cmd_done,
  input logic              gpr_wb_valid,
  input logic [21:0]       stat_q,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              mem_ack
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && !mem_req && !cmd_done && cmd_ready)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready); // R11

  AST_TOGGLE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_op == 4'd8 || cmd_op == 4'd9 || cmd_op == 4'd10))
      |=> ($countones(stat_q ^ $past(stat_q)) == 1)); // R9

  AST_STAT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) |=> $stable(stat_q)); // R9

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    gpr_wb_valid |-> cmd_done); // R6
endmodule

bind fp_bank_regfile fprf_chk #(.DW(DW), .IDX_W(IDX_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_done(cmd_done), .gpr_wb_valid(gpr_wb_valid),
  .stat_q(stat_q), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack));

// File: tb/fp_bank_regfile_bench.sv
module fp_bank_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        cmd_valid = 0, cmd_ready;
  logic [3:0]  cmd_op = 0, cmd_n = 0, cmd_m = 0;
  logic [31:0] cmd_base = 0, cmd_ofs = 0, cmd_wdata = 0;
  logic        cmd_done, gpr_wb_valid;
  logic [31:0] gpr_wb_data;
  logic [21:0] stat_q;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [4:0]  rd_phys = 0;
  logic [31:0] rd_data;

  int nchk = 0, nerr = 0, ack_delay = 0;

  typedef struct { logic [31:0] addr; logic we; logic [31:0] data; string tag; } mem_item_t;
  mem_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_bank_regfile u_fp_bank_regfile (.*);

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic we, input logic [31:0] d, input string tag);
    mem_item_t it;
    it.addr = a; it.we = we; it.data = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic rd(input logic [4:0] p, output logic [31:0] v);
    @(negedge clk) rd_phys = p;
    @(negedge clk) v = rd_data;
  endtask

  task automatic run(input logic [3:0] op, input logic [3:0] n, input logic [3:0] m,
                     input logic [31:0] base, input logic [31:0] ofs, input logic [31:0] wd,
                     input logic wb, input logic [31:0] wbv, input string tag, output int waits);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_n = n; cmd_m = m;
    cmd_base = base; cmd_ofs = ofs; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    waits = 0;
    while (!cmd_done) begin @(negedge clk); waits++; end
    chk({tag, " wb_valid"}, 32'(gpr_wb_valid), 32'(wb));
    if (wb) chk({tag, " wb_data"}, gpr_wb_data, wbv);
  endtask

  // Monitor / memory responder: pops expected items as requests appear.
  initial begin
    mem_item_t it;
    logic [31:0] held;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        held = mem_addr;
        for (int d = 0; d < ack_delay; d++) begin
          @(negedge clk);
          chk("R11 hold req", {mem_req, 31'(mem_addr == held)}, {1'b1, 31'd1});
          chk("R11 ready low", 32'(cmd_ready), 32'd0);
        end
        if (exp_q.size() == 0) begin
          nchk++; nerr++;
          $display("FAIL unexpected request got %h exp none", mem_addr);
        end else begin
          it = exp_q.pop_front();
          chk({it.tag, " addr"}, mem_addr, it.addr);
          chk({it.tag, " we"}, 32'(mem_we), 32'(it.we));
          if (it.we) chk({it.tag, " wdata"}, mem_wdata, it.data);
        end
        mem_rdata = memf(mem_addr);
        mem_ack = 1;
        @(negedge clk);
        mem_ack = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired got hang exp completion");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stat", 32'(stat_q), 32'd0);
    chk("R1 ready/req", {30'd0, cmd_ready, mem_req}, 32'd2);
    rd(5'd0, v);  chk("R1 reg0", v, 32'd0);
    rd(5'd31, v); chk("R1 reg31", v, 32'd0);

    // R13 single load
    push(32'h100, 0, 0, "R13 single load");
    run(4'd1, 4'd3, 0, 32'h100, 0, 0, 0, 0, "R13", w);
    rd(5'd3, v); chk("R13 p3", v, memf(32'h100));

    // R2 bank toggle then load
    run(4'd10, 0, 0, 0, 0, 0, 0, 0, "R9 bank", w);
    chk("R9 bank bit", 32'(stat_q), 32'h20_0000);
    push(32'h200, 0, 0, "R2 banked load");
    run(4'd1, 4'd3, 0, 32'h200, 0, 0, 0, 0, "R2", w);
    rd(5'd19, v); chk("R2 p19", v, memf(32'h200));
    rd(5'd3, v);  chk("R2 p3 untouched", v, memf(32'h100));
    run(4'd10, 0, 0, 0, 0, 0, 0, 0, "R9 bank back", w);

    // R9 precision and size toggles
    run(4'd9, 0, 0, 0, 0, 0, 0, 0, "R9 prec", w);
    chk("R9 prec bit", 32'(stat_q), 32'h08_0000);
    run(4'd8, 0, 0, 0, 0, 0, 0, 0, "R9 size", w);
    chk("R9 size bit", 32'(stat_q), 32'h18_0000);
    run(4'd9, 0, 0, 0, 0, 0, 0, 0, "R9 prec back", w);
    chk("R9 only size", 32'(stat_q), 32'h10_0000);

    // R4 paired load, even index
    push(32'h304, 0, 0, "R4 first word");
    push(32'h300, 0, 0, "R4 second word");
    run(4'd1, 4'd4, 0, 32'h300, 0, 0, 0, 0, "R4", w);
    rd(5'd4, v); chk("R4 p4", v, memf(32'h304));
    rd(5'd5, v); chk("R4 p5", v, memf(32'h300));

    // R3 + R6 paired post-increment, odd index -> other bank pair
    push(32'h404, 0, 0, "R3 first");
    push(32'h400, 0, 0, "R3 second");
    run(4'd3, 4'd5, 0, 32'h400, 0, 0, 1, 32'h408, "R6 paired inc", w);
    rd(5'd20, v); chk("R3 p20", v, memf(32'h404));
    rd(5'd21, v); chk("R3 p21", v, memf(32'h400));

    // R5 + R7 paired pre-decrement store
    push(32'h4FC, 1, memf(32'h304), "R5 first");
    push(32'h4F8, 1, memf(32'h300), "R5 second");
    run(4'd6, 4'd4, 0, 32'h500, 0, 0, 1, 32'h4F8, "R7 paired dec", w);

    // R12 paired register move m=4 -> n=1 (pair 16/17)
    run(4'd7, 4'd1, 4'd4, 0, 0, 0, 0, 0, "R12", w);
    chk("R12 one cycle", 32'(w), 32'd0);
    rd(5'd16, v); chk("R12 p16", v, memf(32'h304));
    rd(5'd17, v); chk("R12 p17", v, memf(32'h300));

    // single mode forms
    run(4'd8, 0, 0, 0, 0, 0, 0, 0, "R9 size off", w);
    push(32'h624, 0, 0, "R8 indexed load");
    run(4'd2, 4'd7, 0, 32'h600, 32'h24, 0, 0, 0, "R8", w);
    rd(5'd7, v); chk("R8 p7", v, memf(32'h624));
    push(32'h710, 1, memf(32'h100), "R8 indexed store");
    run(4'd5, 4'd3, 0, 32'h700, 32'h10, 0, 0, 0, "R8 st", w);
    push(32'h800, 0, 0, "R6 single inc");
    run(4'd3, 4'd2, 0, 32'h800, 0, 0, 1, 32'h804, "R6 single", w);
    push(32'h8FC, 1, memf(32'h800), "R7 single dec");
    run(4'd6, 4'd2, 0, 32'h900, 0, 0, 1, 32'h8FC, "R7 single", w);
    // single register move
    run(4'd7, 4'd9, 4'd7, 0, 0, 0, 0, 0, "R12 single", w);
    rd(5'd9, v); chk("R12 p9", v, memf(32'h624));
    rd(5'd8, v); chk("R12 p8 untouched", v, 32'd0);

    // R10 status write mask
    run(4'd11, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, "R10", w);
    chk("R10 mask", 32'(stat_q), 32'h3F_FFFF);
    // bank + paired: odd index 1 -> 16 -> bank -> 0
    run(4'd11, 0, 0, 0, 0, 32'h0030_0000, 0, 0, "R10 set", w);
    push(32'hA04, 0, 0, "R3 banked first");
    push(32'hA00, 0, 0, "R3 banked second");
    run(4'd1, 4'd1, 0, 32'hA00, 0, 0, 0, 0, "R3 banked", w);
    rd(5'd0, v); chk("R3 p0", v, memf(32'hA04));
    rd(5'd1, v); chk("R3 p1", v, memf(32'hA00));

    // R11 stalled memory
    run(4'd11, 0, 0, 0, 0, 0, 0, 0, "R10 clear", w);
    ack_delay = 3;
    push(32'hB00, 0, 0, "R11 stalled load");
    run(4'd1, 4'd9, 0, 32'hB00, 0, 0, 0, 0, "R11", w);
    rd(5'd9, v); chk("R11 p9", v, memf(32'hB00));
    ack_delay = 0;

    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule